// File: doc/BRIEF.md
# Watchdog Timer with Two-Byte Feed Unlock

This block is a bus-attached watchdog. A free-running counter advances on every clock while the watchdog is running. Two independent thresholds are compared against it. Each threshold is a power of two chosen by its own 4-bit exponent code. Crossing the first threshold latches an interrupt flag. Crossing the second threshold, when reset requests are allowed, pulses a system reset request for one clock, latches a sticky reset-cause flag and restarts the counter.

Software sees one 32-bit control/status word and one write-only feed word on a single-cycle bus (address, write strobe, write data, combinational read data). The counter can only be restarted by software through an ordered pair of feed writes: 0xA5 and then 0x5A. The parameter `EXP_SHIFT` lowers every exponent by a fixed amount, so short runs can still reach both thresholds.

Top module: `feedlock_wdt`

## Requirements
- R1: After `rst_n` is low, the control word reads 0x0000_0000, and `irq_o` and `reset_req_o` are low.
- R2: Interrupt code n sits in control bits 3:0. The period is P = 2^(31-EXP_SHIFT-n). If the counter restarts at edge E, the interrupt flag (bit 9) sets at edge E+P, counting only edges where bit 8 was set before the edge.
- R3: Reset code m sits in control bits 7:4 and uses the same encoding. When bit 11 and bit 8 are set and the counter reaches the reset period, three things happen at that edge: `reset_req_o` goes high for exactly one clock, bit 31 sets, and the counter restarts from zero.
- R4: The interrupt flag sets whatever the value of bit 10. `irq_o` is high exactly when bit 9 and bit 10 are both 1.
- R5: A control write with bit 9 = 0 clears the interrupt flag. Bit 9 = 1 leaves it unchanged. A threshold hit on the same edge wins over the clear.
- R6: Bit 31 clears only when `rst_n` is low or when a control write has bit 31 = 0. Writing 1 and later reset requests leave it set. A reset hit on the same edge wins over the clear.
- R7: While bit 8 is 0, the counter is held at zero and no flag or request is raised.
- R8: A feed write is a write at byte offset 0x04. A feed write with low byte 0x5A that directly follows one with low byte 0xA5 restarts the counter on its own edge.
- R9: Any other feed value written after 0xA5 cancels the armed state. A 0x5A that is not armed has no effect. A repeated 0xA5 keeps the state armed.
- R10: The control word sits at offset 0x00 and reads back with these fields: bits 3:0 interrupt code, 7:4 reset code, 8 run, 9 interrupt flag, 10 interrupt enable, 11 reset enable, 31 reset flag. All other bits read 0. Reads at the feed offset and at unmapped offsets return 0, and writes to unmapped offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | ADDR_W (4) | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Interrupt output |
| reset_req_o | output | 1 | One-clock system reset request |

## Verification
The assertions assume the bus presents at most one write per clock, with address and data stable around the edge. They also assume `EXP_SHIFT` stays at or below 15, so that every period is at least two counts and a restart can never coincide with a threshold hit. The bench drives all inputs at falling edges, holds each write for exactly one cycle, and uses a shift of 12. Random control writes force the upper two bits of both codes to 1, which keeps every period between 16 and 128 clocks and lets both thresholds, including restarts racing with feed sequences, be reached many times in a short run.

// File: rtl/wdt_feed_pkg.sv
package wdt_feed_pkg;

  localparam int WORD_W = 32;

  localparam logic [7:0] KEY_ARM  = 8'hA5;
  localparam logic [7:0] KEY_FIRE = 8'h5A;

  localparam int OFF_CTRL = 0;
  localparam int OFF_FEED = 4;

  localparam int B_RUN   = 8;
  localparam int B_IFLAG = 9;
  localparam int B_IEN   = 10;
  localparam int B_REN   = 11;
  localparam int B_RFLAG = 31;

  typedef struct packed {
    logic       rflag;
    logic       ren;
    logic       ien;
    logic       iflag;
    logic       run;
    logic [3:0] rcode;
    logic [3:0] icode;
  } ctrl_t;

  // Last counter value before a period of 2^(31-shift-code) expires.
  function automatic logic [31:0] last_count(input logic [3:0] code, input int shift);
    int         e;
    logic [31:0] one;
    e   = 31 - shift - int'(code);
    one = 32'd1;
    return (one << e) - 32'd1;
  endfunction

  function automatic logic [31:0] ctrl_word(input ctrl_t c);
    logic [31:0] w;
    w          = '0;
    w[3:0]     = c.icode;
    w[7:4]     = c.rcode;
    w[B_RUN]   = c.run;
    w[B_IFLAG] = c.iflag;
    w[B_IEN]   = c.ien;
    w[B_REN]   = c.ren;
    w[B_RFLAG] = c.rflag;
    return w;
  endfunction

endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_feed_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_feed,
  input  logic [7:0] wr_byte,
  output logic       feed_ok
);

  logic armed_q;

  assign feed_ok = wr_feed && armed_q && (wr_byte == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_feed) begin
      armed_q <= (wr_byte == KEY_ARM);
    end
  end

endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_feed_pkg::*;
#(
  parameter int EXP_SHIFT = 0,
  parameter int CNT_W     = 32 - EXP_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rst_en,
  input  logic [3:0]       int_code,
  input  logic [3:0]       rst_code,
  input  logic             restart_sw,
  output logic [CNT_W-1:0] cnt,
  output logic             int_hit,
  output logic             rst_hit
);

  logic [31:0] int_last;
  logic [31:0] rst_last;
  logic        unused_hi;

  assign int_last  = last_count(int_code, EXP_SHIFT);
  assign rst_last  = last_count(rst_code, EXP_SHIFT);
  assign unused_hi = ^{int_last, rst_last};

  assign int_hit = run && (cnt == int_last[CNT_W-1:0]);
  assign rst_hit = run && rst_en && (cnt == rst_last[CNT_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || rst_hit || restart_sw) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_feed_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  input  logic        int_hit,
  input  logic        rst_hit,
  output ctrl_t       ctrl
);

  logic unused_wd;
  assign unused_wd = ^wdata[30:12];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.icode <= wdata[3:0];
        ctrl.rcode <= wdata[7:4];
        ctrl.run   <= wdata[B_RUN];
        ctrl.ien   <= wdata[B_IEN];
        ctrl.ren   <= wdata[B_REN];
      end
      if (int_hit) begin
        ctrl.iflag <= 1'b1;
      end else if (wr_ctrl && !wdata[B_IFLAG]) begin
        ctrl.iflag <= 1'b0;
      end
      if (rst_hit) begin
        ctrl.rflag <= 1'b1;
      end else if (wr_ctrl && !wdata[B_RFLAG]) begin
        ctrl.rflag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/feedlock_wdt.sv
module feedlock_wdt
  import wdt_feed_pkg::*;
#(
  parameter int EXP_SHIFT = 0,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              reset_req_o
);

  localparam int CNT_W = 32 - EXP_SHIFT;

  logic             sel_ctrl;
  logic             sel_feed;
  logic             ctrl_wr;
  logic             feed_wr;
  logic             feed_ok;
  logic             int_hit;
  logic             rst_hit;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl;
  logic             req_q;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_feed = (bus_addr == ADDR_W'(OFF_FEED));
  assign ctrl_wr  = bus_we && sel_ctrl;
  assign feed_wr  = bus_we && sel_feed;

  wdt_feed_seq feed_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_feed (feed_wr),
    .wr_byte (bus_wdata[7:0]),
    .feed_ok (feed_ok)
  );

  wdt_count #(
    .EXP_SHIFT (EXP_SHIFT),
    .CNT_W     (CNT_W)
  ) count_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl.run),
    .rst_en     (ctrl.ren),
    .int_code   (ctrl.icode),
    .rst_code   (ctrl.rcode),
    .restart_sw (feed_ok),
    .cnt        (cnt),
    .int_hit    (int_hit),
    .rst_hit    (rst_hit)
  );

  wdt_ctrl_reg regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (ctrl_wr),
    .wdata   (bus_wdata),
    .int_hit (int_hit),
    .rst_hit (rst_hit),
    .ctrl    (ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= rst_hit;
    end
  end

  assign bus_rdata   = sel_ctrl ? ctrl_word(ctrl) : '0;
  assign irq_o       = ctrl.iflag && ctrl.ien;
  assign reset_req_o = req_q;

endmodule

// File: rtl/wdt_feed_chk.sv
module wdt_feed_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic [31:0]      bus_wdata,
  input logic             feed_ok,
  input logic             run,
  input logic             ren,
  input logic             int_flag,
  input logic             rst_flag,
  input logic [CNT_W-1:0] cnt,
  input logic             reset_req_o
);

  AST_FEED_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (cnt == '0)); // R8

  AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R7

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o); // R3

  AST_REQ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> (cnt == '0)); // R3

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(ren && run)); // R3

  AST_REQ_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> rst_flag); // R6

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flag && !(ctrl_wr && !bus_wdata[31])) |=> rst_flag); // R6

  AST_IFLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && !(ctrl_wr && !bus_wdata[9])) |=> int_flag); // R5

endmodule

bind feedlock_wdt wdt_feed_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_wr     (ctrl_wr),
  .bus_wdata   (bus_wdata),
  .feed_ok     (feed_ok),
  .run         (ctrl.run),
  .ren         (ctrl.ren),
  .int_flag    (ctrl.iflag),
  .rst_flag    (ctrl.rflag),
  .cnt         (cnt),
  .reset_req_o (reset_req_o)
);

// File: tb/feedlock_wdt_tb_top.sv
module feedlock_wdt_tb_top;

  localparam int SHIFT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        reset_req_o;

  int n_chk = 0;
  int n_err = 0;

  // reference state, built from the requirements
  int unsigned m_cnt = 0;
  bit m_armed = 0, m_run = 0, m_ien = 0, m_ren = 0, m_if = 0, m_rf = 0, m_req = 0;
  bit [3:0] m_ic = 0, m_rc = 0;

  always #5 clk = ~clk;

  feedlock_wdt #(.EXP_SHIFT(SHIFT), .ADDR_W(4)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .reset_req_o (reset_req_o)
  );

  function automatic int unsigned period(input bit [3:0] code);
    return 32'd1 << (31 - SHIFT - int'(code));
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = {m_rf, 19'd0, m_ren, m_ien, m_if, m_run, m_rc, m_ic};
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit we, input bit [3:0] a, input bit [31:0] d);
    bit hi, hr, fd;
    hi = m_run && (m_cnt == period(m_ic) - 1);
    hr = m_run && m_ren && (m_cnt == period(m_rc) - 1);
    fd = 0;
    if (we && a == 4'd4) begin
      if (d[7:0] == 8'hA5) m_armed = 1;
      else if (d[7:0] == 8'h5A && m_armed) begin fd = 1; m_armed = 0; end
      else m_armed = 0;
    end
    if (!m_run || hr || fd) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    if (hi) m_if = 1;
    else if (we && a == 4'd0 && !d[9]) m_if = 0;
    if (hr) m_rf = 1;
    else if (we && a == 4'd0 && !d[31]) m_rf = 0;
    if (we && a == 4'd0) begin
      m_ic = d[3:0]; m_rc = d[7:4]; m_run = d[8]; m_ien = d[10]; m_ren = d[11];
    end
    m_req = hr;
  endtask

  // one clock: drive at the falling edge, compare after the next falling edge
  task automatic step(input bit we, input bit [3:0] a, input bit [31:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    model_edge(we, a, d);
    bus_we = 0;
    chk("R4 irq_o", {31'd0, irq_o}, {31'd0, m_ien & m_if});
    chk("R3 reset_req_o", {31'd0, reset_req_o}, {31'd0, m_req});
    bus_addr = 4'd0;
    #1;
    chk("R10 control readback", bus_rdata, exp_word());
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 4'd0, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    bus_addr = 4'd0; #1;
    chk("R1 control after reset", bus_rdata, 32'h0);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1 reset_req after reset", {31'd0, reset_req_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = 4'd4; #1;
    chk("R10 feed offset reads zero", bus_rdata, 32'h0);

    // R7: not running, interrupt enabled with shortest period
    step(1, 4'd0, 32'h0000_04EF);
    idle(40);
    chk("R7 no flag while halted", {31'd0, bus_rdata[9]}, 32'd0);

    // R2: start, flag appears exactly 16 clocks later
    step(1, 4'd0, 32'h0000_05EF);
    idle(15);
    chk("R2 flag not before period", {31'd0, irq_o}, 32'd0);
    idle(1);
    chk("R2 flag at period", {31'd0, irq_o}, 32'd1);

    // R5: write-one keeps, write-zero clears
    step(1, 4'd0, 32'h0000_07EF);
    chk("R5 write one keeps flag", {31'd0, irq_o}, 32'd1);
    step(1, 4'd0, 32'h0000_05EF);
    chk("R5 write zero clears flag", {31'd0, irq_o}, 32'd0);

    // R4: flag sets with interrupt output masked
    step(1, 4'd0, 32'h0000_00EF);
    step(1, 4'd0, 32'h0000_01EF);
    idle(16);
    chk("R4 flag sets while masked", {31'd0, bus_rdata[9]}, 32'd1);
    chk("R4 output masked", {31'd0, irq_o}, 32'd0);

    // R3: reset period 16
    step(1, 4'd0, 32'h0);
    step(1, 4'd0, 32'h0000_09FE);
    idle(15);
    chk("R3 no request before period", {31'd0, reset_req_o}, 32'd0);
    idle(1);
    chk("R3 request at period", {31'd0, reset_req_o}, 32'd1);
    chk("R6 cause flag set", {31'd0, bus_rdata[31]}, 32'd1);
    idle(1);
    chk("R3 request lasts one clock", {31'd0, reset_req_o}, 32'd0);
    step(1, 4'd0, 32'h8000_09FE);
    chk("R6 write one keeps cause", {31'd0, bus_rdata[31]}, 32'd1);
    step(1, 4'd0, 32'h0000_09FE);
    chk("R6 write zero clears cause", {31'd0, bus_rdata[31]}, 32'd0);

    // R9: broken sequence does not restart (reset period 32)
    step(1, 4'd0, 32'h0);
    step(1, 4'd0, 32'h0000_09E0);
    idle(9);
    step(1, 4'd4, 32'h0000_00A5);
    step(1, 4'd4, 32'h0000_0033);
    step(1, 4'd4, 32'h0000_005A);
    idle(19);
    chk("R9 no early request", {31'd0, reset_req_o}, 32'd0);
    idle(1);
    chk("R9 cancelled sequence left count running", {31'd0, reset_req_o}, 32'd1);

    // R8: proper pair restarts on the second write
    idle(5);
    step(1, 4'd4, 32'hFFFF_FFA5);
    step(1, 4'd4, 32'h1234_565A);
    idle(31);
    chk("R8 restart delays request", {31'd0, reset_req_o}, 32'd0);
    idle(1);
    chk("R8 request one period after feed", {31'd0, reset_req_o}, 32'd1);

    // R9: repeated arm byte stays armed
    step(1, 4'd4, 32'h0000_00A5);
    step(1, 4'd4, 32'h0000_00A5);
    step(1, 4'd4, 32'h0000_005A);
    idle(31);
    chk("R9 repeated arm then fire restarts", {31'd0, reset_req_o}, 32'd0);
    idle(1);
    chk("R9 request after re-armed restart", {31'd0, reset_req_o}, 32'd1);

    // random traffic against the reference model
    for (int k = 0; k < 3000; k++) begin
      int unsigned op;
      bit [31:0] d;
      op = $urandom % 16;
      d = $urandom;
      if (op == 0) begin
        d[8] = ($urandom % 8) != 0;
        d[7:6] = 2'b11;
        d[3:2] = 2'b11;
        step(1, 4'd0, d);
      end else if (op <= 3) begin
        case ($urandom % 3)
          0: d[7:0] = 8'hA5;
          1: d[7:0] = 8'h5A;
          default: ;
        endcase
        step(1, 4'd4, d);
      end else if (op == 4) begin
        step(1, 4'd8, d);
      end else begin
        step(0, 4'd0, 32'd0);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule